// File: doc/BRIEF.md
# Prescaled Wake-Up Countdown Timer

This block raises a periodic wake-up event for a low-power subsystem. A one-cycle `tick` strobe marks each period of a 32.768 kHz reference. The block runs on a faster system clock. A prescaler divides the tick by one of eight fixed ratios. A 16-bit down-counter steps once per prescaler output and emits a one-clock `wakePulse` when its period expires. It then reloads from the programmed value and counts again.

Software programs the block through a byte-wide write port with four addresses. The 16-bit reload value and the configuration are each split across two registers. The first register of each pair is staged. It takes effect only when its partner register is written, and both halves then apply together. Each commit restarts the prescaler and the counter, so the first timeout after an update is a full period.

The clock-source and oscillator-enable bits are stored and shown on outputs. They have no other effect inside the block.

Top module: `wake_timer`

## Requirements
- R1: After reset, `curCount` is 0, `wakePulse` is 0, and `clkSelRc`, `rcOscEn` and `xtalOscEn` are 0. All configuration and reload registers are 0.
- R2: Address 2 stages the reload high byte (bits 15:8). Address 3 carries the low byte (bits 7:0) and commits {staged high, low} as the active reload value. A write to address 2 alone does not change the active value.
- R3: Address 0 stages configuration byte A, with the prescaler code in bits 2:0. Address 1 carries configuration byte B and commits A and B together. A write to address 0 alone changes no behaviour or output.
- R4: Prescaler codes 0 to 7 divide the tick by 1, 4, 8, 16, 128, 1024, 8192 and 65536.
- R5: While armed, `curCount` shows the count. It holds the reload value R after a restart and drops by one on each prescaler output. It runs R, R-1, …, 1.
- R6: When a prescaler output finds the count at 1, `wakePulse` goes high for exactly one clock and the count reloads R. The wake period is divider×R ticks, repeating without software action.
- R7: With R = 0, every prescaler output produces a wake pulse.
- R8: Byte B bit 0 is the arm bit. While it is 0, `curCount` equals the active reload value, the prescaler is cleared and no wake pulse occurs.
- R9: A write to address 1 or address 3 restarts the prescaler and the counter. The next wake pulse follows a full period after the write.
- R10: Byte B bit 1 drives `clkSelRc` (1 = RC oscillator, 0 = crystal). Bit 2 drives `rcOscEn` and bit 3 drives `xtalOscEn`. These bits change neither the count nor the wake timing.
- R11: Clocks in which `tick` is low leave the count and the prescaler unchanged and produce no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe per 32.768 kHz period |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Register address (0 cfg A, 1 cfg B, 2 reload high, 3 reload low) |
| wrData | input | 8 | Register write data |
| wakePulse | output | 1 | One-clock wake-up event |
| curCount | output | 16 | Current down-counter value |
| clkSelRc | output | 1 | Stored clock-source select |
| rcOscEn | output | 1 | Stored RC oscillator enable |
| xtalOscEn | output | 1 | Stored crystal oscillator enable |

## Verification
A committing write acts on the clock edge that samples it. The new reload value, the arm state and the restarted count are therefore all visible one cycle later. When `tick` is held high, the wake pulse appears exactly divider×R edges after the commit edge. The bench counts falling edges from the end of each commit and requires the pulse on exactly that falling edge. It requires the pulse to be gone on the following falling edge. Count steps are sampled on the falling edges just before and just after each prescaler boundary.

// File: rtl/wut_pkg.sv
package wut_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic restart;  // a commit happened this cycle
    logic hold;     // timer not armed
    logic step;     // prescaler output tick
  } wutStrobes_t;

  // log2 of the divider selected by each prescaler code
  function automatic int divShift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: divShift = 0;
      3'd1: divShift = 2;
      3'd2: divShift = 3;
      3'd3: divShift = 4;
      3'd4: divShift = 7;
      3'd5: divShift = 10;
      3'd6: divShift = 13;
      default: divShift = 16;
    endcase
  endfunction

  localparam int PRESC_W = 16;  // largest shift
endpackage

// File: rtl/wut_ctrl.sv
module wut_ctrl
  import wut_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  output wutStrobes_t           strobes,
  output logic [2*DATA_W-1:0]   reloadNext,
  output logic                  clkSelRc,
  output logic                  rcOscEn,
  output logic                  xtalOscEn
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_CFG_A  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CFG_B  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_REL_HI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_REL_LO = ADDR_W'(3);

  logic [DATA_W-1:0]  relHiStage;
  logic [CNT_W-1:0]   reloadVal;
  logic [SEL_W-1:0]   selStage;
  logic [SEL_W-1:0]   prescSel;
  logic               armed;
  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLimit;
  logic wrCfgA, wrCfgB, wrRelHi, wrRelLo;

  assign wrCfgA  = wrEn && (wrAddr == ADDR_CFG_A);
  assign wrCfgB  = wrEn && (wrAddr == ADDR_CFG_B);
  assign wrRelHi = wrEn && (wrAddr == ADDR_REL_HI);
  assign wrRelLo = wrEn && (wrAddr == ADDR_REL_LO);

  always_comb begin
    reloadNext = wrRelLo ? {relHiStage, wrData} : reloadVal;
    prescLimit = PRESC_W'(((PRESC_W+1)'(1) << divShift(prescSel)) - (PRESC_W+1)'(1));
    strobes.restart = wrRelLo || wrCfgB;
    strobes.hold    = !armed;
    strobes.step    = tick && armed && (prescCnt == prescLimit) && !strobes.restart;
  end

  // register file with staged halves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relHiStage <= '0;
      reloadVal  <= '0;
      selStage   <= '0;
      prescSel   <= '0;
      armed      <= 1'b0;
      clkSelRc   <= 1'b0;
      rcOscEn    <= 1'b0;
      xtalOscEn  <= 1'b0;
    end else begin
      if (wrRelHi) relHiStage <= wrData;
      if (wrRelLo) reloadVal  <= {relHiStage, wrData};
      if (wrCfgA)  selStage   <= wrData[SEL_W-1:0];
      if (wrCfgB) begin
        prescSel  <= selStage;
        armed     <= wrData[0];
        clkSelRc  <= wrData[1];
        rcOscEn   <= wrData[2];
        xtalOscEn <= wrData[3];
      end
    end
  end

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (strobes.restart || !armed) begin
      prescCnt <= '0;
    end else if (tick) begin
      prescCnt <= (prescCnt == prescLimit) ? '0 : prescCnt + 1'b1;
    end
  end

  a_r2_reload_held: assert property (@(posedge clk) disable iff (!rstN)
    !wrRelLo |=> $stable(reloadVal));
  a_r3_cfg_held: assert property (@(posedge clk) disable iff (!rstN)
    !wrCfgB |=> ($stable(prescSel) && $stable(armed) && $stable(clkSelRc)));
  a_r4_presc_range: assert property (@(posedge clk) disable iff (!rstN)
    prescCnt <= prescLimit);
  a_r11_presc_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobes.restart && armed) |=> $stable(prescCnt));
endmodule

// File: rtl/wut_dp.sv
module wut_dp
  import wut_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  wutStrobes_t      strobes,
  input  logic [CNT_W-1:0] reloadNext,
  output logic [CNT_W-1:0] count,
  output logic             wakePulse
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= 1'b0;
      if (strobes.restart || strobes.hold) begin
        count <= reloadNext;
      end else if (strobes.step) begin
        if (count <= ONE) begin
          count     <= reloadNext;
          wakePulse <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  a_r8_no_wake_unarmed: assert property (@(posedge clk) disable iff (!rstN)
    strobes.hold |=> !wakePulse);
  a_r5_step_dec: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.hold && count > ONE) |=> (count == $past(count) - ONE));
  a_r6_wake_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.hold && count <= ONE) |=> wakePulse);
  a_r9_restart_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> (count == $past(reloadNext) && !wakePulse));
  a_r11_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.step && !strobes.restart && !strobes.hold) |=> ($stable(count) && !wakePulse));
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wut_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic                wakePulse,
  output logic [2*DATA_W-1:0] curCount,
  output logic                clkSelRc,
  output logic                rcOscEn,
  output logic                xtalOscEn
);
  localparam int CNT_W = 2 * DATA_W;

  wutStrobes_t      strobes;
  logic [CNT_W-1:0] reloadNext;

  wut_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobes(strobes), .reloadNext(reloadNext),
    .clkSelRc(clkSelRc), .rcOscEn(rcOscEn), .xtalOscEn(xtalOscEn)
  );

  wut_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reloadNext(reloadNext),
    .count(curCount), .wakePulse(wakePulse)
  );
endmodule

// File: tb/wake_timer_tb.sv
module wake_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic wakePulse, clkSelRc, rcOscEn, xtalOscEn;
  logic [15:0] curCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_timer u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wakePulse(wakePulse), .curCount(curCount),
    .clkSelRc(clkSelRc), .rcOscEn(rcOscEn), .xtalOscEn(xtalOscEn)
  );

  localparam int NV = 11;
  // prescaler code, reload value, expected wake period in ticks (R4 R6 R7)
  localparam int VSEL[NV] = '{0, 0, 0, 1, 2, 3, 4, 5, 6, 0, 2};
  localparam int VREL[NV] = '{1, 0, 5, 3, 2, 4, 2, 1, 1, 258, 0};
  localparam int VEXP[NV] = '{1, 1, 5, 12, 16, 64, 256, 1024, 8192, 258, 8};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitWake(output int n);
    n = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk);
      n++;
      if (wakePulse) return;
    end
    n = -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", curCount, 0);
    check("R1 wake", wakePulse, 0);
    check("R1 cfg outs", {clkSelRc, rcOscEn, xtalOscEn}, 0);

    // R10 reported-only bits (byte B bits 1..3)
    tick = 1'b1;
    wr(2'd0, 8'hFF);
    check("R3 staged A no effect", {clkSelRc, rcOscEn, xtalOscEn}, 0);
    wr(2'd1, 8'b0000_1110);
    check("R10 cfg outs", {clkSelRc, rcOscEn, xtalOscEn}, 7);
    check("R10 count untouched", curCount, 0);
    wr(2'd1, 8'b0000_0010);
    check("R10 clkSel only", {clkSelRc, rcOscEn, xtalOscEn}, 4);
    wr(2'd1, 8'h00);

    // R2 staging of the reload value
    wr(2'd2, 8'h12);
    wr(2'd3, 8'h34);
    check("R2 committed", curCount, 16'h1234);
    wr(2'd2, 8'h56);
    check("R2 high staged only", curCount, 16'h1234);
    wr(2'd3, 8'h78);
    check("R2 both bytes", curCount, 16'h5678);

    // R8 unarmed: held, no pulse
    c0 = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (wakePulse) c0++;
    end
    check("R8 no wake", c0, 0);
    check("R8 count held", curCount, 16'h5678);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 8'(VREL[i] >> 8));
      wr(2'd3, 8'(VREL[i]));
      wr(2'd0, 8'(VSEL[i]));
      wr(2'd1, 8'h01);
      waitWake(n);
      check($sformatf("R4 R6 first period sel %0d rel %0d", VSEL[i], VREL[i]), n, VEXP[i]);
      waitWake(n);
      check($sformatf("R6 R7 repeat period sel %0d rel %0d", VSEL[i], VREL[i]), n, VEXP[i]);
      if (VEXP[i] > 1) begin
        @(negedge clk);
        check("R6 one-cycle pulse", wakePulse, 0);
      end
    end

    // R5 count sequence, div 4, R=3
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h01);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 3)  check("R5 count before step", curCount, 3);
      if (k == 4)  check("R5 first step", curCount, 2);
      if (k == 8)  check("R5 second step", curCount, 1);
      if (k == 11) check("R5 no early wake", wakePulse, 0);
      if (k == 12) begin
        check("R6 wake at expiry", wakePulse, 1);
        check("R6 reload after wake", curCount, 3);
      end
    end

    // R11 tick low freezes everything
    @(negedge clk);
    tick = 1'b0;
    c0 = curCount;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (wakePulse) n++;
    end
    check("R11 count frozen", curCount, c0);
    check("R11 no wake", n, 0);
    tick = 1'b1;

    // R3 staged prescaler code takes effect only with byte B
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h04);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    waitWake(n);
    waitWake(n);
    check("R3 staged code inactive", n, 4);
    wr(2'd1, 8'h01);
    waitWake(n);
    check("R3 R9 commit period", n, 16);

    // R9 mid-count reload restart, div 1
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h0A);
    wr(2'd1, 8'h01);
    repeat (6) @(negedge clk);
    wr(2'd3, 8'h0A);
    waitWake(n);
    check("R9 full period after restart", n, 10);

    // R8 disarm mid-count
    repeat (3) @(negedge clk);
    wr(2'd1, 8'h00);
    check("R8 count back to reload", curCount, 10);
    n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (wakePulse) n++;
    end
    check("R8 no wake after disarm", n, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule